// File: doc/BRIEF.md
# Port-Size Byte-Lane Steering Unit

This unit connects a 32-bit internal operand path to an external data bus. The bus numbers its bits from the most significant end, so bus bit 0 is the MSB. For each access it takes a transfer size (byte, halfword or word), the two low address bits and the width of the attached port (32-bit or 16-bit). From these it decides which external byte lanes carry which operand bytes. A write drives the selected lanes and forces every other lane to zero. A read gathers the captured lanes back into operand order.

A 16-bit port sits on the two most significant lanes. The unit moves the lower operand half onto those lanes when it is addressed. A word access to a 16-bit port runs as two bus beats.

Each request is checked for alignment before any bus activity starts. A misaligned request gets a single-cycle transfer-error response and no bus beat. The unit handles one access at a time. A request that arrives while a beat is in progress is dropped.

Top module: `lane_steer`

## Requirements
- R1: After reset, `bus_valid`, `bus_we`, `bus_be`, `bus_dout`, `rd_data`, `done` and `xfer_err` are all zero.
- R2: Operand byte OPk (OP0 = `wr_data[31:24]`, down to OP3 = `wr_data[7:0]`) maps to lane k on a 32-bit port. Lane k occupies `bus_dout[31-8k -: 8]` and is enabled by `bus_be[k]`. Size codes are 00 byte, 01 halfword, 10 word, and a word access on a 32-bit port sets `bus_be` = 4'b1111.
- R3: On a 32-bit port, a byte access at address a uses only OPa on lane a. A halfword at address 0 uses OP0/OP1 on lanes 0/1. A halfword at address 2 uses OP2/OP3 on lanes 2/3.
- R4: When `port16` is 1 at acceptance, only lanes 0 and 1 (`bus_dout[31:16]`) are used. OP2 and OP3 are steered onto lanes 0 and 1, and `bus_be[3:2]` stays zero.
- R5: A word access to a 16-bit port runs two beats. The first beat carries OP0/OP1 and the second carries OP2/OP3, both with `bus_be` = 4'b0011. `done` follows only the second acknowledge.
- R6: On writes, every lane whose enable is low is driven to zero.
- R7: On a read, the data of each enabled lane is stored at the matching operand byte position of `rd_data`. Operand bytes outside the access are zero, and the bus lanes that are not enabled are ignored. `rd_data` holds its value until the next accepted request.
- R8: A request is misaligned when the size is a halfword with `req_addr[0]`=1, a word with `req_addr`≠0, or size code 11. The cycle after a misaligned request is seen, `xfer_err` is 1 for exactly one cycle. No bus beat starts for it, and `bus_be` stays zero.
- R9: `bus_valid` stays high through wait states until `bus_ack`. `done` is a one-cycle pulse in the cycle after the final acknowledge.
- R10: A request presented while an access is in progress is ignored: the current beat is unchanged and no further beat follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port16 | input | 1 | Attached port is 16 bits wide (sampled at acceptance) |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word |
| req_addr | input | 2 | Low two address bits |
| wr_data | input | 32 | Write operand, OP0 in bits 31:24 |
| bus_din | input | 32 | External data bus input, bus bit 0 = bit 31 |
| bus_ack | input | 1 | Beat acknowledge |
| bus_valid | output | 1 | Beat in progress |
| bus_we | output | 1 | Beat direction is write |
| bus_be | output | 4 | Lane enables, bit k = lane k |
| bus_dout | output | 32 | External data bus output |
| rd_data | output | 32 | Reassembled read operand |
| done | output | 1 | Access complete pulse |
| xfer_err | output | 1 | Misaligned-access error pulse |

## Verification
The hardest situation to reach from the ports is the boundary between the two beats of a word access on a 16-bit port. Lane steering must switch from the upper operand half to the lower one while `done` stays low, and on reads the first captured half must survive the second capture. The stimulus acknowledges each beat separately and samples lane enables, bus data and `done` between the two acknowledges. It uses different data on each beat and nonzero data on the unused lanes.

// File: rtl/lane_steer_pkg.sv
`timescale 1ns/1ps
package lane_steer_pkg;
   localparam int unsigned LANES = 4;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10,
      SZ_BAD  = 2'b11
   } xfer_size_e;

   typedef struct packed {
      logic       write;
      logic [1:0] size;
      logic [1:0] addr;
      logic       narrow;
   } xfer_t;

   function automatic logic is_misaligned(input logic [1:0] sz, input logic [1:0] a);
      case (sz)
         SZ_BYTE: return 1'b0;
         SZ_HALF: return a[0];
         SZ_WORD: return |a;
         default: return 1'b1;
      endcase
   endfunction
endpackage

// File: rtl/lane_steer_ctrl.sv
`timescale 1ns/1ps
module lane_steer_ctrl
   import lane_steer_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  req_valid,
   input  xfer_t req,
   input  logic  bus_ack,
   output logic  active,
   output logic  beat,
   output xfer_t cur,
   output logic  accept,
   output logic  done,
   output logic  xfer_err
);
   logic bad_req;
   logic split;

   assign bad_req = is_misaligned(req.size, req.addr);
   assign accept  = !active && req_valid && !bad_req;
   assign split   = cur.narrow && (cur.size == SZ_WORD);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active   <= 1'b0;
         beat     <= 1'b0;
         done     <= 1'b0;
         xfer_err <= 1'b0;
         cur      <= '0;
      end else begin
         done     <= 1'b0;
         xfer_err <= 1'b0;
         if (!active) begin
            if (req_valid) begin
               if (bad_req) begin
                  xfer_err <= 1'b1;
               end else begin
                  active <= 1'b1;
                  beat   <= 1'b0;
                  cur    <= req;
               end
            end
         end else if (bus_ack) begin
            if (split && !beat) begin
               beat <= 1'b1;
            end else begin
               active <= 1'b0;
               beat   <= 1'b0;
               done   <= 1'b1;
            end
         end
      end
   end

   // R8
   err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_err |=> !xfer_err);
   // R8
   err_no_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_err |-> !active);
   // R9
   done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(bus_ack));
   // R10
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !bus_ack) |=> (active && $stable(cur) && $stable(beat)));
endmodule

// File: rtl/lane_steer_map.sv
`timescale 1ns/1ps
module lane_steer_map
   import lane_steer_pkg::*;
#(
   parameter int unsigned LANE_W    = 8,
   parameter bit          NARROW_EN = 1'b1,
   localparam int unsigned DW       = LANES * LANE_W
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    active,
   input  logic                    beat,
   input  logic                    narrow,
   input  logic [1:0]              size,
   input  logic [1:0]              addr,
   input  logic [DW-1:0]           wr_data,
   output logic [LANES-1:0]        lane_en,
   output logic [LANES-1:0][1:0]   lane_op,
   output logic [DW-1:0]           lane_dout
);
   logic                narrow_q;
   logic [1:0]          base;
   logic [LANES-1:0]    op_mask;
   logic [LANE_W-1:0]   op_b [LANES];

   assign narrow_q = NARROW_EN && narrow;

   always_comb begin
      base = (narrow_q && size == SZ_WORD) ? {beat, 1'b0} : addr;
      case (size)
         SZ_BYTE: op_mask = 4'b0001 << base;
         SZ_HALF: op_mask = 4'b0011 << base;
         SZ_WORD: op_mask = narrow_q ? (4'b0011 << base) : 4'b1111;
         default: op_mask = 4'b0000;
      endcase
   end

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      localparam logic [1:0] K = 2'(k);
      assign op_b[k] = wr_data[DW-1-k*LANE_W -: LANE_W];
      if (NARROW_EN && k < 2) begin : g_low
         assign lane_op[k] = narrow_q ? (K | {base[1], 1'b0}) : K;
         assign lane_en[k] = active && op_mask[lane_op[k]];
      end else if (NARROW_EN) begin : g_high
         assign lane_op[k] = K;
         assign lane_en[k] = active && !narrow_q && op_mask[k];
      end else begin : g_wide
         assign lane_op[k] = K;
         assign lane_en[k] = active && op_mask[k];
      end
      assign lane_dout[DW-1-k*LANE_W -: LANE_W] = lane_en[k] ? op_b[lane_op[k]] : '0;
   end

   // R4
   narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && narrow_q) |-> (lane_en[3:2] == 2'b00));
   // R2
   beat_has_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (lane_en != '0));
   // R2
   idle_no_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> (lane_en == '0));
endmodule

// File: rtl/lane_steer_rdcap.sv
`timescale 1ns/1ps
module lane_steer_rdcap
   import lane_steer_pkg::*;
#(
   parameter int unsigned LANE_W = 8,
   localparam int unsigned DW    = LANES * LANE_W
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clear,
   input  logic                  cap,
   input  logic [LANES-1:0]      lane_en,
   input  logic [LANES-1:0][1:0] lane_op,
   input  logic [DW-1:0]         bus_din,
   output logic [DW-1:0]         rd_data
);
   logic [LANE_W-1:0] din_b [LANES];
   logic [LANE_W-1:0] rd_b  [LANES];

   for (genvar k = 0; k < LANES; k++) begin : g_split
      assign din_b[k] = bus_din[DW-1-k*LANE_W -: LANE_W];
      assign rd_data[DW-1-k*LANE_W -: LANE_W] = rd_b[k];
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         for (int i = 0; i < LANES; i++) rd_b[i] <= '0;
      end else if (cap) begin
         for (int i = 0; i < LANES; i++)
            if (lane_en[i]) rd_b[lane_op[i]] <= din_b[i];
      end
   end

   // R7
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && !cap) |=> $stable(rd_data));
endmodule

// File: rtl/lane_steer.sv
`timescale 1ns/1ps
module lane_steer
   import lane_steer_pkg::*;
#(
   parameter int unsigned LANE_W    = 8,
   parameter bit          NARROW_EN = 1'b1,
   localparam int unsigned DW       = LANES * LANE_W
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             port16,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic [1:0]       req_size,
   input  logic [1:0]       req_addr,
   input  logic [DW-1:0]    wr_data,
   input  logic [DW-1:0]    bus_din,
   input  logic             bus_ack,
   output logic             bus_valid,
   output logic             bus_we,
   output logic [LANES-1:0] bus_be,
   output logic [DW-1:0]    bus_dout,
   output logic [DW-1:0]    rd_data,
   output logic             done,
   output logic             xfer_err
);
   if (LANE_W < 1) begin : g_bad_lane_w
      $error("lane_steer: LANE_W must be at least 1");
   end

   xfer_t                  req;
   xfer_t                  cur;
   logic                   active;
   logic                   beat;
   logic                   accept;
   logic [LANES-1:0][1:0]  lane_op;
   logic [DW-1:0]          lane_dout;

   assign req = '{write: req_write, size: req_size, addr: req_addr, narrow: port16};

   lane_steer_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_valid(req_valid),
      .req      (req),
      .bus_ack  (bus_ack),
      .active   (active),
      .beat     (beat),
      .cur      (cur),
      .accept   (accept),
      .done     (done),
      .xfer_err (xfer_err)
   );

   lane_steer_map #(.LANE_W(LANE_W), .NARROW_EN(NARROW_EN)) u_map (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (active),
      .beat     (beat),
      .narrow   (cur.narrow),
      .size     (cur.size),
      .addr     (cur.addr),
      .wr_data  (wr_data),
      .lane_en  (bus_be),
      .lane_op  (lane_op),
      .lane_dout(lane_dout)
   );

   lane_steer_rdcap #(.LANE_W(LANE_W)) u_rdcap (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (accept),
      .cap    (active && bus_ack && !cur.write),
      .lane_en(bus_be),
      .lane_op(lane_op),
      .bus_din(bus_din),
      .rd_data(rd_data)
   );

   assign bus_valid = active;
   assign bus_we    = active && cur.write;
   assign bus_dout  = bus_we ? lane_dout : '0;

   // R8
   err_quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_err |-> (bus_be == '0 && !bus_valid));
   // R6
   off_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && !bus_be[3]) |-> (bus_dout[LANE_W-1:0] == '0));
   // R9
   done_ends_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !bus_valid);
endmodule

// File: tb/lane_steer_bench.sv
`timescale 1ns/1ps
module lane_steer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        port16 = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [1:0]  req_size = 2'b00;
   logic [1:0]  req_addr = 2'b00;
   logic [31:0] wr_data = '0;
   logic [31:0] bus_din = '0;
   logic        bus_ack = 1'b0;
   logic        bus_valid, bus_we, done, xfer_err;
   logic [3:0]  bus_be;
   logic [31:0] bus_dout, rd_data;

   int nchk = 0;
   int nfail = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   lane_steer u_lane_steer (
      .clk(clk), .rst_n(rst_n), .port16(port16), .req_valid(req_valid),
      .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
      .wr_data(wr_data), .bus_din(bus_din), .bus_ack(bus_ack),
      .bus_valid(bus_valid), .bus_we(bus_we), .bus_be(bus_be),
      .bus_dout(bus_dout), .rd_data(rd_data), .done(done), .xfer_err(xfer_err)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic start_req(input bit w, input logic [1:0] sz, input logic [1:0] a,
                            input bit p16);
      @(negedge clk);
      req_write = w; req_size = sz; req_addr = a; port16 = p16; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic beat(input string tag, input logic [3:0] exp_be, input logic [31:0] exp_dout,
                       input logic [31:0] din, input bit last);
      check({tag, " valid"}, 32'(bus_valid), 32'd1);
      check({tag, " be"}, 32'(bus_be), 32'(exp_be));
      if (req_write) check({tag, " dout"}, bus_dout, exp_dout);
      bus_din = din; bus_ack = 1'b1;
      @(negedge clk);
      bus_ack = 1'b0;
      check({tag, " done"}, 32'(done), 32'(last));
   endtask

   task automatic t_reset();
      check("R1 valid", 32'(bus_valid), 0);
      check("R1 we", 32'(bus_we), 0);
      check("R1 be", 32'(bus_be), 0);
      check("R1 dout", bus_dout, 0);
      check("R1 rd", rd_data, 0);
      check("R1 done", 32'(done), 0);
      check("R1 err", 32'(xfer_err), 0);
   endtask

   task automatic t_wide_writes();
      wr_data = 32'hA1B2C3D4;
      start_req(1, 2'b10, 2'd0, 0); beat("R2 word32", 4'b1111, 32'hA1B2C3D4, 0, 1);
      @(negedge clk); check("R9 done pulse", 32'(done), 0);
      start_req(1, 2'b00, 2'd2, 0); beat("R3 R6 byte32@2", 4'b0100, 32'h0000C300, 0, 1);
      start_req(1, 2'b00, 2'd0, 0); beat("R3 byte32@0", 4'b0001, 32'hA1000000, 0, 1);
      start_req(1, 2'b01, 2'd2, 0); beat("R3 half32@2", 4'b1100, 32'h0000C3D4, 0, 1);
      start_req(1, 2'b01, 2'd0, 0); beat("R3 half32@0", 4'b0011, 32'hA1B20000, 0, 1);
   endtask

   task automatic t_narrow_writes();
      wr_data = 32'hA1B2C3D4;
      start_req(1, 2'b00, 2'd3, 1); beat("R4 byte16@3", 4'b0010, 32'h00D40000, 0, 1);
      start_req(1, 2'b00, 2'd0, 1); beat("R4 byte16@0", 4'b0001, 32'hA1000000, 0, 1);
      start_req(1, 2'b01, 2'd2, 1); beat("R4 half16@2", 4'b0011, 32'hC3D40000, 0, 1);
      start_req(1, 2'b10, 2'd0, 1);
      beat("R5 word16 beat1", 4'b0011, 32'hA1B20000, 0, 0);
      beat("R5 word16 beat2", 4'b0011, 32'hC3D40000, 0, 1);
   endtask

   task automatic t_reads();
      wr_data = 32'hFFFFFFFF;
      start_req(0, 2'b10, 2'd0, 0); beat("R7 word32 rd", 4'b1111, 0, 32'h11223344, 1);
      check("R7 word32 data", rd_data, 32'h11223344);
      start_req(0, 2'b00, 2'd1, 0); beat("R7 byte32@1 rd", 4'b0010, 0, 32'h11223344, 1);
      check("R7 byte32 data", rd_data, 32'h00220000);
      start_req(0, 2'b01, 2'd2, 1); beat("R7 half16@2 rd", 4'b0011, 0, 32'h55667788, 1);
      check("R7 R4 half16 data", rd_data, 32'h00005566);
      start_req(0, 2'b10, 2'd0, 1);
      beat("R5 word16 rd beat1", 4'b0011, 0, 32'hAABB9999, 0);
      beat("R5 word16 rd beat2", 4'b0011, 0, 32'hEEFF1234, 1);
      check("R5 R7 word16 data", rd_data, 32'hAABBEEFF);
      @(negedge clk);
      check("R7 rd hold", rd_data, 32'hAABBEEFF);
   endtask

   task automatic t_misaligned(input string tag, input logic [1:0] sz, input logic [1:0] a);
      start_req(1, sz, a, 0);
      check({tag, " err"}, 32'(xfer_err), 1);
      check({tag, " valid"}, 32'(bus_valid), 0);
      check({tag, " be"}, 32'(bus_be), 0);
      @(negedge clk);
      check({tag, " err one cycle"}, 32'(xfer_err), 0);
      check({tag, " no beat"}, 32'(bus_valid), 0);
   endtask

   task automatic t_wait_states();
      start_req(0, 2'b10, 2'd0, 0);
      for (int i = 0; i < 3; i++) begin
         check("R9 wait valid", 32'(bus_valid), 1);
         check("R9 wait done", 32'(done), 0);
         @(negedge clk);
      end
      beat("R9 after wait", 4'b1111, 0, 32'h0BADCAFE, 1);
      check("R9 wait data", rd_data, 32'h0BADCAFE);
   endtask

   task automatic t_busy_ignore();
      wr_data = 32'h01020304;
      start_req(1, 2'b10, 2'd0, 0);
      req_write = 1; req_size = 2'b00; req_addr = 2'd3; port16 = 1; req_valid = 1'b1;
      @(negedge clk);
      check("R10 be kept", 32'(bus_be), 32'hF);
      check("R10 dout kept", bus_dout, 32'h01020304);
      req_valid = 1'b0;
      beat("R10 finish", 4'b1111, 32'h01020304, 0, 1);
      @(negedge clk);
      check("R10 no extra beat", 32'(bus_valid), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_wide_writes();
      t_narrow_writes();
      t_reads();
      t_misaligned("R8 half@1", 2'b01, 2'd1);
      t_misaligned("R8 word@2", 2'b10, 2'd2);
      t_misaligned("R8 size11", 2'b11, 2'd0);
      t_wait_states();
      t_busy_ignore();
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         nchk++;
         nfail++;
         $display("FAIL watchdog R9: actual hung expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end
endmodule